// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block turns a stereo pair of parallel samples into a bit-serial audio stream. Data leave MSB first, in two's-complement form. The left and right words alternate on one data line, and a word clock marks which channel is being sent. The bit clock comes from outside and runs without pause, including through the unused positions of each channel slot. The block runs on a fast system clock and watches the bit clock through a synchroniser. Every event on the outputs is tied to a detected falling edge of the bit clock.

Each channel owns a slot of 32 bit clocks, so a stereo frame is 64 bit clocks long. Samples arrive 20 bits wide. Strap pins choose how many of the top bits are sent (16, 18 or 20) and where the word sits in its slot. The word can be packed against the end of the slot, start at its first position, or follow the I2S convention: the word clock is low for the left channel and the MSB comes one bit clock after the word-clock edge. When I2S timing is chosen, it overrides the justification pin. A new pair offered with a valid strobe is held in a buffer. It is taken into use only at the start of the next left slot.

Top module: `sao_serial_tx`

## Requirements
- R1: While reset is asserted and after it is released, `sdo` is low and `lrck` sits at the right-channel level (0 when `cfg_i2s_n` is high, 1 when it is low). The first bit-clock fall after reset enters position 0 of the left slot.
- R2: A frame is 64 bit-clock periods: positions 0..31 carry the left slot and 32..63 the right slot. `lrck` changes only when a slot starts. It is 1 for left when `cfg_i2s_n` is high and 0 for left when `cfg_i2s_n` is low.
- R3: Word length decode, with the pins active low: `cfg_w20_n` low gives 20 bits whatever `cfg_w18_n` is, in both timing modes. Otherwise `cfg_w18_n` low gives 18 bits. Both pins high gives 16 bits.
- R4: The word sent is the top W bits of the 20-bit input sample, MSB first, and the bit pattern is not altered.
- R5: With `cfg_i2s_n` high and `cfg_front` low, the word is rear packed: its LSB falls at slot position 31 and its MSB at position 32-W.
- R6: With `cfg_i2s_n` high and `cfg_front` high, the word is front packed: its MSB falls at slot position 0.
- R7: With `cfg_i2s_n` low, the MSB falls at slot position 1, one bit clock after the `lrck` edge, whatever `cfg_front` is.
- R8: Every slot position outside the word is driven low.
- R9: `sdo` and `lrck` change only in the system-clock cycle that follows a detected falling edge of `bck`.
- R10: A pair is taken from the input buffer only when the left slot starts. A valid strobe in the middle of a frame leaves the rest of that frame unchanged. With no new strobe, the last pair is sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `bck` |
| rst | input | 1 | Synchronous active-high reset |
| bck | input | 1 | Continuous serial bit clock |
| cfg_i2s_n | input | 1 | Low selects I2S timing |
| cfg_w20_n | input | 1 | Low selects 20-bit words |
| cfg_w18_n | input | 1 | Low selects 18-bit words (when `cfg_w20_n` is high) |
| cfg_front | input | 1 | High selects front packing in non-I2S timing |
| in_valid | input | 1 | Strobe that captures `in_left`/`in_right` |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| sdo | output | 1 | Serial data |
| lrck | output | 1 | Word clock (channel indicator) |

## Verification
A wrong slot position counter shows up at once. It shifts every word inside its slot and moves the `lrck` edge, so a single 64-bit-clock frame compared bit for bit reveals it. A wrong width or justification decode leaves `lrck` correct but places or truncates the word, and that also shows within one frame. A buffer that loads at the wrong moment corrupts only the frame in which a mid-frame strobe arrives, so the bench offers data in the middle of a frame and checks that frame and the next one.

// File: rtl/sao_pkg.sv
package sao_pkg;

    localparam int SMP_W = 20;

    typedef logic [SMP_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    typedef enum logic [1:0] {
        WL16 = 2'd0,
        WL18 = 2'd1,
        WL20 = 2'd2
    } wlen_e;

    typedef enum logic [1:0] {
        ALIGN_REAR  = 2'd0,
        ALIGN_FRONT = 2'd1,
        ALIGN_I2S   = 2'd2
    } align_e;

    // The 20-bit select wins over the 18-bit select in every timing mode.
    function automatic wlen_e decode_wlen(input logic w20_n, input logic w18_n);
        if (!w20_n)      return WL20;
        else if (!w18_n) return WL18;
        else             return WL16;
    endfunction

    function automatic int wlen_bits(input wlen_e wl);
        case (wl)
            WL20:    return 20;
            WL18:    return 18;
            default: return 16;
        endcase
    endfunction

    // I2S timing overrides the justification strap.
    function automatic align_e decode_align(input logic i2s_n, input logic front);
        if (!i2s_n)     return ALIGN_I2S;
        else if (front) return ALIGN_FRONT;
        else            return ALIGN_REAR;
    endfunction

endpackage

// File: rtl/sao_bck_edge.sv
module sao_bck_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bck,
    output logic fall
);
    logic bck_s;
    logic bck_q;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign bck_s = bck;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], bck} >> 0;
            end
            assign bck_s = chain[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) bck_q <= 1'b1;
        else     bck_q <= bck_s;
    end

    assign fall = bck_q & ~bck_s;

endmodule

// File: rtl/sao_framer.sv
module sao_framer
    import sao_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              fall,
    input  align_e                            align,
    output logic [$clog2(2*SLOT_W)-1:0]       pos,
    output logic [$clog2(2*SLOT_W)-1:0]       pos_next,
    output logic                              left_start,
    output logic                              lrck
);
    localparam int FRAME_W = 2 * SLOT_W;
    localparam int POS_W   = $clog2(FRAME_W);
    localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0] SLOT_LAST = POS_W'(SLOT_W - 1);
    localparam logic [POS_W-1:0] SLOT_POS  = POS_W'(SLOT_W);

    logic left_level;

    assign left_level = (align != ALIGN_I2S);
    assign pos_next   = (pos == LAST_POS) ? '0 : pos + 1'b1;
    assign left_start = fall && (pos_next == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos  <= LAST_POS;
            lrck <= ~left_level;
        end else if (fall) begin
            pos  <= pos_next;
            lrck <= (pos_next < SLOT_POS) ? left_level : ~left_level;
        end
    end

    a_r2_frame_wrap: assert property (@(posedge clk) disable iff (rst)
        (fall && pos == LAST_POS) |=> (pos == '0));

    a_r2_lrck_slot_edge_only: assert property (@(posedge clk) disable iff (rst)
        (fall && pos != SLOT_LAST && pos != LAST_POS) |=> $stable(lrck));

endmodule

// File: rtl/sao_sample_buf.sv
module sao_sample_buf
    import sao_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t in_left,
    input  sample_t in_right,
    input  logic    load,
    output pair_t   pend,
    output pair_t   work
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (in_valid) begin
            pend.left  <= in_left;
            pend.right <= in_right;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       work <= '0;
        else if (load) work <= pend;
    end

    a_r10_work_held: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(work));

endmodule

// File: rtl/sao_bitsel.sv
module sao_bitsel
    import sao_pkg::*;
#(
    parameter int SLOT_W = 32
) (
    input  logic [$clog2(2*SLOT_W)-1:0] pos,
    input  pair_t                       src,
    input  wlen_e                       wlen,
    input  align_e                      align,
    output logic                        bit_o
);
    localparam int IDX_W = $clog2(SMP_W);

    always_comb begin
        int      p;
        int      w;
        int      start;
        int      k;
        sample_t word;
        logic    is_right;

        is_right = (int'(pos) >= SLOT_W);
        p        = is_right ? int'(pos) - SLOT_W : int'(pos);
        word     = is_right ? src.right : src.left;
        w        = wlen_bits(wlen);
        case (align)
            ALIGN_REAR:  start = SLOT_W - w;
            ALIGN_FRONT: start = 0;
            default:     start = 1;
        endcase
        k     = p - start;
        bit_o = 1'b0;
        if (k >= 0 && k < w) bit_o = word[IDX_W'(SMP_W - 1 - k)];
    end

endmodule

// File: rtl/sao_serial_tx.sv
module sao_serial_tx
    import sao_pkg::*;
#(
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bck,
    input  logic             cfg_i2s_n,
    input  logic             cfg_w20_n,
    input  logic             cfg_w18_n,
    input  logic             cfg_front,
    input  logic             in_valid,
    input  logic [SMP_W-1:0] in_left,
    input  logic [SMP_W-1:0] in_right,
    output logic             sdo,
    output logic             lrck
);
    localparam int POS_W = $clog2(2 * SLOT_W);

    logic             fall;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] pos_next;
    logic             left_start;
    pair_t            pend;
    pair_t            work;
    pair_t            src;
    wlen_e            wlen;
    align_e           align;
    logic             next_bit;

    assign wlen  = decode_wlen(cfg_w20_n, cfg_w18_n);
    assign align = decode_align(cfg_i2s_n, cfg_front);

    sao_bck_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .bck  (bck),
        .fall (fall)
    );

    sao_framer #(.SLOT_W(SLOT_W)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .fall       (fall),
        .align      (align),
        .pos        (pos),
        .pos_next   (pos_next),
        .left_start (left_start),
        .lrck       (lrck)
    );

    sao_sample_buf u_buf (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_left  (in_left),
        .in_right (in_right),
        .load     (left_start),
        .pend     (pend),
        .work     (work)
    );

    // The pair entering use at the left slot start feeds its own first bit.
    assign src = left_start ? pend : work;

    sao_bitsel #(.SLOT_W(SLOT_W)) u_bitsel (
        .pos   (pos_next),
        .src   (src),
        .wlen  (wlen),
        .align (align),
        .bit_o (next_bit)
    );

    always_ff @(posedge clk) begin
        if (rst)       sdo <= 1'b0;
        else if (fall) sdo <= next_bit;
    end

    a_r9_quiet_between_falls: assert property (@(posedge clk) disable iff (rst)
        !fall |=> ($stable(sdo) && $stable(lrck)));

    a_r2_left_level_at_start: assert property (@(posedge clk) disable iff (rst)
        left_start |=> (lrck == cfg_i2s_n));

    a_r1_pos_idle_is_last: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !fall) |-> (pos == POS_W'(2 * SLOT_W - 1)));

endmodule

// File: tb/sao_serial_tx_test.sv
module sao_serial_tx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bck = 1'b1;
    logic        cfg_i2s_n = 1'b1;
    logic        cfg_w20_n = 1'b1;
    logic        cfg_w18_n = 1'b1;
    logic        cfg_front = 1'b0;
    logic        in_valid = 1'b0;
    logic [19:0] in_left = '0;
    logic [19:0] in_right = '0;
    logic        sdo;
    logic        lrck;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sao_serial_tx uut (
        .clk(clk), .rst(rst), .bck(bck),
        .cfg_i2s_n(cfg_i2s_n), .cfg_w20_n(cfg_w20_n), .cfg_w18_n(cfg_w18_n),
        .cfg_front(cfg_front), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .sdo(sdo), .lrck(lrck)
    );

    // mode = {i2s_n, w20_n, w18_n, front}, then left, right
    localparam int NV = 9;
    localparam logic [43:0] VEC [NV] = '{
        {4'b1110, 20'hA5C3F, 20'h12345},  // R5 rear 16
        {4'b1100, 20'h80001, 20'h7FFFE},  // R5 rear 18
        {4'b1010, 20'hFFFFF, 20'h00001},  // R5 rear 20
        {4'b1001, 20'h5A5A5, 20'hC3C3C},  // R6 front 20, both selects low
        {4'b1111, 20'hF0F0F, 20'h0F0F0},  // R6 front 16
        {4'b0110, 20'h9ABCD, 20'h3FFFF},  // R7 I2S 16, front pin low ignored
        {4'b0101, 20'h7FFFF, 20'h80000},  // R7 I2S 18, front pin high ignored
        {4'b0010, 20'hDEADB, 20'h54321},  // R3 I2S 20 override
        {4'b0001, 20'h13579, 20'hEACE1}   // R3 I2S 20, both low
    };

    function automatic logic [63:0] exp_sdo(input logic [3:0] m, input logic [19:0] l, input logic [19:0] r);
        logic [63:0] f;
        int w;
        w = !m[2] ? 20 : (!m[1] ? 18 : 16);
        f = '0;
        for (int ch = 0; ch < 2; ch++) begin
            logic [31:0] slot;
            logic [31:0] word;
            word = {12'b0, (ch == 0) ? l : r} >> (20 - w);
            if (!m[3])     slot = word << (32 - w - 1);
            else if (m[0]) slot = word << (32 - w);
            else           slot = word;
            for (int p = 0; p < 32; p++) f[ch*32 + p] = slot[31 - p];
        end
        return f;
    endfunction

    function automatic logic [63:0] exp_lrck(input logic [3:0] m);
        return m[3] ? {32'h0, 32'hFFFF_FFFF} : {32'hFFFF_FFFF, 32'h0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        {cfg_i2s_n, cfg_w20_n, cfg_w18_n, cfg_front} = m;
    endtask

    task automatic offer(input logic [19:0] l, input logic [19:0] r);
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic step(output logic s, output logic w);
        @(negedge clk);
        bck = 1'b0;
        repeat (4) @(negedge clk);
        s = sdo; w = lrck;
        bck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(output logic [63:0] fs, output logic [63:0] fw);
        for (int p = 0; p < 64; p++) step(fs[p], fw[p]);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst = 1'b1; bck = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [63:0] fs, fw, a_s;
        logic        s1, w1;

        // R1: reset state in both timing modes
        set_mode(4'b1110);
        do_reset();
        check("R1 idle sdo/lrck non-I2S", {62'b0, sdo, lrck}, 64'h0);
        set_mode(4'b0110);
        do_reset();
        check("R1 idle sdo/lrck I2S", {62'b0, sdo, lrck}, 64'h1);

        // R1/R9: the outputs stay put while bck holds still, even with new data
        offer(20'hFFFFF, 20'hFFFFF);
        repeat (20) @(negedge clk);
        check("R9 no change without bck fall", {62'b0, sdo, lrck}, 64'h1);

        // Table: R2..R8
        set_mode(4'b1110);
        do_reset();
        for (int i = 0; i < NV; i++) begin
            logic [3:0]  m;
            logic [19:0] l, r;
            {m, l, r} = VEC[i];
            set_mode(m);
            offer(l, r);
            frame(fs, fw);
            check($sformatf("R4/R5/R6/R7/R8 sdo frame vec %0d", i), fs, exp_sdo(m, l, r));
            check($sformatf("R2 lrck frame vec %0d", i), fw, exp_lrck(m));
        end

        // R10: a mid-frame strobe does not disturb the frame in progress
        set_mode(4'b1001);
        offer(20'h2468A, 20'hBDF13);
        for (int p = 0; p < 10; p++) step(a_s[p], fw[p]);
        offer(20'h97531, 20'h0ACE5);
        for (int p = 10; p < 64; p++) step(a_s[p], fw[p]);
        check("R10 frame unchanged by mid-frame strobe", a_s, exp_sdo(4'b1001, 20'h2468A, 20'hBDF13));
        frame(fs, fw);
        check("R10 new pair used at next left start", fs, exp_sdo(4'b1001, 20'h97531, 20'h0ACE5));
        frame(fs, fw);
        check("R10 last pair repeats without strobe", fs, exp_sdo(4'b1001, 20'h97531, 20'h0ACE5));

        // R1: first fall after reset enters left slot position 0 (front 20, MSB 1)
        set_mode(4'b1011);
        do_reset();
        offer(20'h80000, 20'h00000);
        step(s1, w1);
        check("R1 first fall is left slot position 0", {62'b0, s1, w1}, 64'h3);

        done = 1'b1;
        finish_run();
    end

endmodule